// File: doc/BRIEF.md
# Framebuffer Pixel Unpacker

The unpacker takes one checked 15-byte payload and turns it into a run of word writes into a framebuffer SRAM that is 16 bits wide. The framebuffer is laid out as `ROW_WORDS` words per row, with 320 words by default. Each word carries two 8-bit pixels. Each pixel is coded as red in bits 7:5, green in bits 4:2 and blue in bits 1:0. A host controller presents the payload with a format code and pulses `start`. The block then issues at most one write per cycle on a plain address/data/byte-enable/strobe interface, raises `busy` while it works, and pulses `done` when the packet is finished.

Five payload formats are supported:

- **Full-resolution strip:** 12 separate pixels, written one byte lane at a time.
- **Wide-tall strip:** each colour byte fills a whole word, and the word is written to two adjacent rows.
- **Wide strip:** the same as wide-tall, but written to one row only.
- **Mono strip:** 96 one-bit pixels, expanded to white or black and doubled like the wide-tall strip.
- **Point list:** three separately addressed coloured points.

Control is a single state machine with three states:

- **ST_IDLE** moves to **ST_EMIT** when a start is accepted.
- **ST_EMIT** stays in **ST_EMIT** for one cycle per write slot.
- **ST_EMIT** moves to **ST_FINISH** after the final slot.
- **ST_FINISH** always returns to **ST_IDLE** on the next cycle.

Top module: `pxu_unpacker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are all 0.
- R2: A start is taken only in ST_IDLE and only with a format code from 0 to 4. The codes are 0 full, 1 wide-tall, 2 wide, 3 mono and 4 points. A start with code 5, 6 or 7 is ignored: there is no `busy`, no write and no `done`.
- R3: A start coordinate sits in three payload bytes, where byte k occupies payload bits 8k+7:8k. Byte 0 holds X[9:2]. Byte 1 holds {X[1:0], Y[8:3]}. Byte 2 holds {Y[2:0], 5 unused bits}. Bytes 0 to 2 carry the start coordinate in formats 0 to 3.
- R4: In format 0, pixel k (k = 0..11) is byte 3+k and goes to x = X+k. The write uses address Y*320 + x/2 and data {c,c}. Its byte enable is 2'b01 for even x and 2'b10 for odd x.
- R5: An item whose x lies at or beyond the right edge produces no write but still uses one cycle. The edge is x ≥ 640 in format 0 and x ≥ 320 in the other formats.
- R6: In format 1, item k is byte 3+k and goes to x = X+k. It writes data {c,c} with byte enable 2'b11 to address (2Y)*320+x, and on the very next cycle to address (2Y+1)*320+x.
- R7: In format 2, each item writes {c,c} with byte enable 2'b11 once, to address Y*320+x.
- R8: In format 3, pixel k (k = 0..95) is payload bit 24+k and goes to x = X+k. A 1 gives colour 0xFF and a 0 gives 0x00. Each pixel is written to two rows exactly as in R6.
- R9: In format 4, entry e (e = 0..2) uses bytes 4e..4e+2 as a coordinate laid out as in R3, and byte 4e+3 as its colour. Each entry writes {c,c} with byte enable 2'b11 to Y*320+X. Bytes 12 to 14 have no effect.
- R10: Writes begin the cycle after acceptance, with one write slot per cycle. A slot is one item, or one row of a doubled item that is in range. `busy` is high for exactly the number of slots. `done` is high for one cycle right after `busy` falls.
- R11: A start raised while a packet is in progress is ignored. The packet that was latched completes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to unpack `payload` |
| fmt_sel | input | 3 | Payload format code |
| payload | input | 120 | 15 payload bytes, byte k in bits 8k+7:8k |
| mem_addr | output | ADDR_W | Framebuffer word address |
| mem_wdata | output | 16 | Write data word |
| mem_be | output | 2 | Byte lane enables (bit 0 = bits 7:0) |
| mem_we | output | 1 | Write strobe, one word per cycle |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |

## Verification
The bench targets the right-edge boundary from an odd start in full mode. A design that tested the wrong limit, or tested it before adding the offset, would write off-row words or drop valid pixels there. It runs strips that run past 320 in the doubled and single-row formats, where a wrong skip would still burn two cycles or emit a stray second row. This shifts the `busy` length and the write list. It sets mono bit patterns that differ in every nibble to expose a reversed bit order. It gives a point list with one out-of-range entry and junk in the spare bytes. It fires starts with unused codes and in the middle of a packet: a design that latched them would corrupt the payload or restart the run.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    localparam int PIX_W      = 8;
    localparam int WORD_W     = 2 * PIX_W;
    localparam int PAY_BYTES  = 15;
    localparam int PAY_W      = PAY_BYTES * PIX_W;
    localparam int X_W        = 10;
    localparam int Y_W        = 9;
    localparam int XS_W       = X_W + 1;
    localparam int ROW_W      = Y_W + 1;
    localparam int IDX_W      = 7;
    localparam int STRIP_N    = 12;
    localparam int MONO_N     = STRIP_N * PIX_W;
    localparam int POINT_N    = 3;
    localparam int HDR_BYTES  = 3;
    localparam int POINT_BYTES = 4;

    typedef enum logic [2:0] {
        FMT_FULL      = 3'd0,
        FMT_WIDE_TALL = 3'd1,
        FMT_WIDE      = 3'd2,
        FMT_MONO      = 3'd3,
        FMT_POINTS    = 3'd4
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EMIT   = 2'd1,
        ST_FINISH = 2'd2
    } st_e;

    function automatic logic fmt_valid(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic fmt_doubles(input fmt_e f);
        return (f == FMT_WIDE_TALL) || (f == FMT_MONO);
    endfunction

    function automatic logic [IDX_W-1:0] fmt_last(input fmt_e f);
        logic [IDX_W-1:0] r;
        unique case (f)
            FMT_MONO:   r = IDX_W'(MONO_N - 1);
            FMT_POINTS: r = IDX_W'(POINT_N - 1);
            default:    r = IDX_W'(STRIP_N - 1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pxu_item_sel.sv
module pxu_item_sel
    import pxu_pkg::*;
(
    input  logic [PAY_W-1:0] pay,
    input  fmt_e             fmt,
    input  logic [IDX_W-1:0] idx,
    output logic [XS_W-1:0]  x,
    output logic [Y_W-1:0]   y,
    output logic [PIX_W-1:0] colour
);

    int unsigned hdr_bit;
    int unsigned col_bit;
    logic [X_W-1:0] base_x;

    always_comb begin
        if (fmt == FMT_POINTS)
            hdr_bit = PIX_W * POINT_BYTES * int'(idx[1:0]);
        else
            hdr_bit = 0;

        base_x = {pay[hdr_bit +: 8], pay[hdr_bit + 14 +: 2]};
        y      = {pay[hdr_bit + 8 +: 6], pay[hdr_bit + 21 +: 3]};

        if (fmt == FMT_POINTS)
            x = XS_W'(base_x);
        else
            x = XS_W'(base_x) + XS_W'(idx);

        if (fmt == FMT_POINTS)
            col_bit = hdr_bit + PIX_W * HDR_BYTES;
        else if (int'(idx) < STRIP_N)
            col_bit = PIX_W * (HDR_BYTES + int'(idx));
        else
            col_bit = PIX_W * HDR_BYTES;

        if (fmt == FMT_MONO) begin
            if (int'(idx) < MONO_N)
                colour = pay[PIX_W * HDR_BYTES + int'(idx)] ? {PIX_W{1'b1}} : {PIX_W{1'b0}};
            else
                colour = '0;
        end else begin
            colour = pay[col_bit +: PIX_W];
        end
    end

endmodule

// File: rtl/pxu_addr_gen.sv
module pxu_addr_gen
    import pxu_pkg::*;
#(
    parameter int ROW_WORDS = 320,
    parameter int ADDR_W    = 19
)(
    input  logic              fmt_full,
    input  logic              fmt_dbl,
    input  logic [XS_W-1:0]   x,
    input  logic [Y_W-1:0]    y,
    input  logic              phase,
    input  logic [PIX_W-1:0]  colour,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] wdata,
    output logic [1:0]        be,
    output logic              in_bounds
);

    localparam int FULL_LIMIT = 2 * ROW_WORDS;

    logic [ROW_W-1:0] row;
    logic [XS_W-1:0]  col;

    always_comb begin
        row = fmt_dbl ? {y, phase} : ROW_W'(y);
        col = fmt_full ? (x >> 1) : x;

        if (fmt_full)
            in_bounds = int'(x) < FULL_LIMIT;
        else
            in_bounds = int'(x) < ROW_WORDS;

        addr  = ADDR_W'(int'(row) * ROW_WORDS + int'(col));
        wdata = {colour, colour};

        if (fmt_full)
            be = x[0] ? 2'b10 : 2'b01;
        else
            be = 2'b11;
    end

endmodule

// File: rtl/pxu_ctrl.sv
module pxu_ctrl
    import pxu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       fmt_sel,
    input  fmt_e             fmt_q,
    input  logic             in_bounds,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             phase,
    output logic             we,
    output logic             busy,
    output logic             done
);

    st_e  state, state_nx;
    logic dbl;
    logic second_row;
    logic last_slot;

    always_comb begin
        dbl        = fmt_doubles(fmt_q);
        second_row = dbl && !phase && in_bounds;
        last_slot  = (idx == fmt_last(fmt_q)) && !second_row;
        accept     = (state == ST_IDLE) && start && fmt_valid(fmt_sel);

        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_EMIT;
            ST_EMIT:   if (last_slot) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
            phase <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                idx   <= '0;
                phase <= 1'b0;
            end else if (state == ST_EMIT) begin
                if (second_row) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    idx   <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        we   = (state == ST_EMIT) && in_bounds;
        busy = (state == ST_EMIT);
        done = (state == ST_FINISH);
    end

    AST_PHASE_ONLY_DOUBLED: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> dbl && busy);  // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> !$past(accept));  // R11

endmodule

// File: rtl/pxu_unpacker.sv
module pxu_unpacker
    import pxu_pkg::*;
#(
    parameter int ROW_WORDS = 320,
    parameter int ADDR_W    = 19
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        fmt_sel,
    input  logic [PAY_W-1:0]  payload,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [1:0]        mem_be,
    output logic              mem_we,
    output logic              busy,
    output logic              done
);

    logic [PAY_W-1:0] pay_q;
    fmt_e             fmt_q;
    logic             accept;
    logic [IDX_W-1:0] idx;
    logic             phase;
    logic [XS_W-1:0]  item_x;
    logic [Y_W-1:0]   item_y;
    logic [PIX_W-1:0] item_c;
    logic             in_bounds;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_q <= '0;
            fmt_q <= FMT_FULL;
        end else if (accept) begin
            pay_q <= payload;
            fmt_q <= fmt_e'(fmt_sel);
        end
    end

    pxu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fmt_sel   (fmt_sel),
        .fmt_q     (fmt_q),
        .in_bounds (in_bounds),
        .accept    (accept),
        .idx       (idx),
        .phase     (phase),
        .we        (mem_we),
        .busy      (busy),
        .done      (done)
    );

    pxu_item_sel u_item (
        .pay    (pay_q),
        .fmt    (fmt_q),
        .idx    (idx),
        .x      (item_x),
        .y      (item_y),
        .colour (item_c)
    );

    pxu_addr_gen #(
        .ROW_WORDS (ROW_WORDS),
        .ADDR_W    (ADDR_W)
    ) u_addr (
        .fmt_full  (fmt_q == FMT_FULL),
        .fmt_dbl   (fmt_doubles(fmt_q)),
        .x         (item_x),
        .y         (item_y),
        .phase     (phase),
        .colour    (item_c),
        .addr      (mem_addr),
        .wdata     (mem_wdata),
        .be        (mem_be),
        .in_bounds (in_bounds)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);  // R2
    AST_FULL_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && fmt_q == FMT_FULL |-> $countones(mem_be) == 1);  // R4
    AST_ROW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && phase |-> $past(mem_we) && mem_addr == $past(mem_addr) + ADDR_W'(ROW_WORDS));  // R6
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);  // R10

endmodule

// File: tb/pxu_unpacker_test.sv
module pxu_unpacker_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   fmt_sel = 3'd0;
    logic [119:0] payload = '0;
    logic [18:0]  mem_addr;
    logic [15:0]  mem_wdata;
    logic [1:0]   mem_be;
    logic         mem_we;
    logic         busy;
    logic         done;

    always #2 clk = ~clk;

    pxu_unpacker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
        .payload(payload), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_we(mem_we), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;

    logic [18:0] got_a [0:255];
    logic [15:0] got_d [0:255];
    logic [1:0]  got_b [0:255];
    int          got_n = 0;
    int          busy_n = 0;
    int          done_n = 0;
    bit          recording = 1'b0;

    logic [18:0] exp_a [0:255];
    logic [15:0] exp_d [0:255];
    logic [1:0]  exp_b [0:255];
    int          exp_n;
    int          exp_slots;

    always @(negedge clk) begin
        if (recording) begin
            if (mem_we && got_n < 256) begin
                got_a[got_n] = mem_addr;
                got_d[got_n] = mem_wdata;
                got_b[got_n] = mem_be;
                got_n++;
            end
            if (busy) busy_n++;
            if (done) done_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] coord(input int x, input int y);
        logic [9:0] xx;
        logic [8:0] yy;
        xx = 10'(x);
        yy = 9'(y);
        return {yy[2:0], 5'b0, xx[1:0], yy[8:3], xx[9:2]};
    endfunction

    task automatic push(input int a, input logic [7:0] c, input logic [1:0] b);
        exp_a[exp_n] = 19'(a);
        exp_d[exp_n] = {c, c};
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    // Expected write list built from R3..R9
    task automatic model(input int m, input logic [119:0] p);
        int bx, by, x, n;
        logic [7:0] c;
        exp_n = 0;
        exp_slots = 0;
        if (m == 4) begin
            for (int e = 0; e < 3; e++) begin
                bx = {p[32*e +: 8], p[32*e + 14 +: 2]};
                by = {p[32*e + 8 +: 6], p[32*e + 21 +: 3]};
                c  = p[32*e + 24 +: 8];
                exp_slots++;
                if (bx < 320) push(by * 320 + bx, c, 2'b11);
            end
        end else begin
            bx = {p[7:0], p[15:14]};
            by = {p[13:8], p[23:21]};
            n  = (m == 3) ? 96 : 12;
            for (int k = 0; k < n; k++) begin
                x = bx + k;
                if (m == 3) c = p[24 + k] ? 8'hFF : 8'h00;
                else        c = p[8*(3+k) +: 8];
                if (m == 0) begin
                    exp_slots++;
                    if (x < 640) push(by * 320 + x / 2, c, (x % 2) ? 2'b10 : 2'b01);
                end else if (m == 2) begin
                    exp_slots++;
                    if (x < 320) push(by * 320 + x, c, 2'b11);
                end else begin
                    if (x < 320) begin
                        exp_slots += 2;
                        push(2 * by * 320 + x, c, 2'b11);
                        push((2 * by + 1) * 320 + x, c, 2'b11);
                    end else begin
                        exp_slots++;
                    end
                end
            end
        end
    endtask

    task automatic run_packet(input int m, input logic [119:0] p, input string req, input bit interfere);
        int waited;
        model(m, p);
        got_n = 0; busy_n = 0; done_n = 0;
        @(negedge clk);
        start = 1'b1; fmt_sel = 3'(m); payload = p;
        recording = 1'b1;
        @(negedge clk);
        start = 1'b0;
        payload = ~p;
        waited = 0;
        while (!done && waited < 400) begin
            if (interfere && waited == 3) begin
                start = 1'b1; fmt_sel = 3'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        repeat (3) @(negedge clk);
        recording = 1'b0;
        check(got_n == exp_n, {req, " write count"}, got_n, exp_n);
        check(busy_n == exp_slots, "R10 busy length", busy_n, exp_slots);
        check(done_n == 1, "R10 single done", done_n, 1);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_a[i] == exp_a[i], {req, " address"}, got_a[i], exp_a[i]);
            check(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
            check(got_b[i] == exp_b[i], {req, " byte enable"}, got_b[i], exp_b[i]);
        end
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(mem_we == 1'b0, "R1 we", mem_we, 0);
    endtask

    task automatic t_full_mid;  // R3 R4
        logic [119:0] p = '0;
        p[23:0] = coord(100, 10);
        for (int k = 0; k < 12; k++) p[8*(3+k) +: 8] = 8'(8'h10 + k * 7);
        run_packet(0, p, "R4", 1'b0);
    endtask

    task automatic t_full_edge;  // R5 odd start near 640
        logic [119:0] p = '0;
        p[23:0] = coord(635, 479);
        for (int k = 0; k < 12; k++) p[8*(3+k) +: 8] = 8'(8'hC1 + k);
        run_packet(0, p, "R5 full edge", 1'b0);
    endtask

    task automatic t_wide_tall;  // R6
        logic [119:0] p = '0;
        p[23:0] = coord(5, 7);
        for (int k = 0; k < 12; k++) p[8*(3+k) +: 8] = 8'(8'h3A ^ (k * 17));
        run_packet(1, p, "R6", 1'b0);
    endtask

    task automatic t_wide_tall_edge;  // R5 R6
        logic [119:0] p = '0;
        p[23:0] = coord(318, 1);
        for (int k = 0; k < 12; k++) p[8*(3+k) +: 8] = 8'(8'h90 + k);
        run_packet(1, p, "R5 doubled edge", 1'b0);
    endtask

    task automatic t_wide;  // R7 R5
        logic [119:0] p = '0;
        p[23:0] = coord(316, 200);
        for (int k = 0; k < 12; k++) p[8*(3+k) +: 8] = 8'(8'h55 + 3 * k);
        run_packet(2, p, "R7", 1'b0);
    endtask

    task automatic t_mono;  // R8
        logic [119:0] p = '0;
        p[23:0] = coord(0, 3);
        p[119:24] = 96'h0123_4567_89AB_CDEF_F00D_5AA5;
        run_packet(3, p, "R8", 1'b0);
    endtask

    task automatic t_points;  // R9
        logic [119:0] p = '0;
        p[23:0]   = coord(0, 0);     p[31:24]  = 8'h11;
        p[55:32]  = coord(319, 239); p[63:56]  = 8'hE3;
        p[87:64]  = coord(400, 5);   p[95:88]  = 8'h07;
        p[119:96] = 24'hFFFFFF;
        run_packet(4, p, "R9", 1'b0);
    endtask

    task automatic t_bad_codes;  // R2
        for (int code = 5; code < 8; code++) begin
            got_n = 0; busy_n = 0; done_n = 0;
            @(negedge clk);
            start = 1'b1; fmt_sel = 3'(code); payload = {120{1'b1}};
            recording = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (8) @(negedge clk);
            recording = 1'b0;
            check(busy_n == 0, "R2 no busy on bad code", busy_n, 0);
            check(got_n == 0, "R2 no write on bad code", got_n, 0);
            check(done_n == 0, "R2 no done on bad code", done_n, 0);
        end
    endtask

    task automatic t_restart;  // R11
        logic [119:0] p = '0;
        p[23:0] = coord(40, 20);
        for (int k = 0; k < 12; k++) p[8*(3+k) +: 8] = 8'(8'hA0 + k);
        run_packet(0, p, "R11", 1'b1);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_mid();
        t_full_edge();
        t_wide_tall();
        t_wide_tall_edge();
        t_wide();
        t_mono();
        t_points();
        t_bad_codes();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule